// File: doc/BRIEF.md
# Prefixed Bit Manipulation Unit

This unit executes the second byte of a two-byte prefixed instruction on one 8-bit operand, and also the two single-byte accumulator rotates. The opcode byte is split into three fields: an operand select in bits [2:0], a bit index or sub-operation in bits [5:3], and a group in bits [7:6]. The group picks one of four actions: test a bit, clear a bit, set a bit, or one of eight shift and rotate forms. Each action has its own flag rule.

The surrounding datapath uses the combinational operand-select outputs to fetch the operand from a register or from memory. It then pulses `start_i` with the opcode, operand and current flag nibble present. One clock later the unit presents a result byte with a write enable, a new flag nibble with a per-flag write mask, and the number of machine cycles the operation costs, so that a sequencer can stall. The register file, memory bus and instruction fetch lie outside the unit.

Flag nibbles on `flags_i`, `flags_o` and `flag_mask_o` use bit 3 = Z (zero), bit 2 = N (subtract), bit 1 = H (half carry), bit 0 = C (carry). This matches bits 7..4 of the processor flag register. Where a mask bit is 0, the matching bit of `flags_o` equals `flags_i`.

Top module: `bitmanip_unit`

## Requirements
- R1: With `prefixed_i`=1, `src_sel_o` equals `opcode_i[2:0]` (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at HL, 7=A). `src_is_mem_o` is 1 only for code 6. With `prefixed_i`=0, `src_sel_o` is 7 and `src_is_mem_o` is 0.
- R2: After reset every registered output is 0. `valid_o` is high for exactly one cycle, the cycle after each clock edge at which `start_i` was high, and low otherwise.
- R3: Group 1 (bit test) gives Z = inverse of `operand_i[opcode_i[5:3]]`, N=0, H=1, and C equal to the input C. The mask is 4'b1110, `result_we_o`=0, and `result_o` equals the operand.
- R4: Group 2 (bit clear) gives `result_o` = operand with bit `opcode_i[5:3]` forced to 0, `result_we_o`=1, mask 0, and `flags_o` = `flags_i`.
- R5: Group 3 (bit set) gives `result_o` = operand with bit `opcode_i[5:3]` forced to 1, `result_we_o`=1, mask 0, and `flags_o` = `flags_i`.
- R6: Group 0 with sub-operation 0 rotates left circularly, and sub-operation 1 rotates right circularly. C takes the bit rotated out.
- R7: Group 0 with sub-operation 2 rotates left through carry, and sub-operation 3 rotates right through carry. The old C enters the vacated end and the bit shifted out becomes C.
- R8: Group 0 with sub-operation 4 shifts left and fills with 0. Sub-operation 5 shifts right and keeps bit 7. Sub-operation 7 shifts right and fills bit 7 with 0. In each case C takes the bit shifted out.
- R9: Group 0 with sub-operation 6 swaps the two nibbles and clears C.
- R10: Every group 0 form gives Z = (result == 0), N=0, H=0, mask 4'b1111 and `result_we_o`=1. The result is truncated to 8 bits.
- R11: `cycles_o` is 2 for a register operand, 4 for the memory operand (select 6), and 1 for an accumulator rotate.
- R12: With `prefixed_i`=0, `opcode_i[3]`=0 rotates the accumulator left circularly and `opcode_i[3]`=1 rotates it right circularly. Z, N and H are cleared even when the result is zero, C takes the bit rotated out, the mask is 4'b1111 and `result_we_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe to execute the presented opcode |
| prefixed_i | input | 1 | 1: prefixed second byte; 0: single-byte accumulator rotate |
| opcode_i | input | 8 | Opcode byte |
| operand_i | input | DATA_W (8) | Operand value fetched by the datapath |
| flags_i | input | 4 | Current flag nibble {Z,N,H,C} |
| src_sel_o | output | 3 | Operand select code for the datapath |
| src_is_mem_o | output | 1 | Operand is memory at HL |
| valid_o | output | 1 | Result outputs are valid this cycle |
| result_o | output | DATA_W (8) | Result byte |
| result_we_o | output | 1 | Write the result back to the operand |
| flags_o | output | 4 | New flag nibble {Z,N,H,C} |
| flag_mask_o | output | 4 | Per-flag write enable |
| cycles_o | output | CYC_W (3) | Machine cycles the operation costs |

## Verification
A wrong field decode or a wrong shifter lane shows at the ports one cycle after the strobe. It appears as a wrong result bit, a wrong carry or a misplaced write enable, so the bench sweeps all 256 prefixed opcodes over operands chosen to expose fill bits and zero results. A wrong flag-mask state would corrupt flags the caller believed untouched, so the bench compares the unmasked flag bits against the incoming nibble on every operation. Any stuck `valid_o` shows on the first idle cycle after an operation.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLEAR = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_ROL_CIRC  = 3'd0,
        SH_ROR_CIRC  = 3'd1,
        SH_ROL_CARRY = 3'd2,
        SH_ROR_CARRY = 3'd3,
        SH_SHL       = 3'd4,
        SH_SHR_ARITH = 3'd5,
        SH_NIB_SWAP  = 3'd6,
        SH_SHR_LOGIC = 3'd7
    } shop_e;

    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_H = 1;
    localparam int FLG_C = 0;

    localparam logic [2:0] SEL_MEM = 3'd6;
    localparam logic [2:0] SEL_ACC = 3'd7;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] idx;
        logic [2:0] sel;
        logic       is_mem;
        logic       acc_form;
    } dec_t;

endpackage

// File: rtl/bitmanip_decode.sv
module bitmanip_decode
    import bitmanip_pkg::*;
(
    input  logic       prefixed_i,
    input  logic [7:0] opcode_i,
    output dec_t       dec_o
);
    always_comb begin
        if (prefixed_i) begin
            dec_o.grp      = grp_e'(opcode_i[7:6]);
            dec_o.idx      = opcode_i[5:3];
            dec_o.sel      = opcode_i[2:0];
            dec_o.is_mem   = (opcode_i[2:0] == SEL_MEM);
            dec_o.acc_form = 1'b0;
        end else begin
            dec_o.grp      = GRP_SHIFT;
            dec_o.idx      = opcode_i[3] ? 3'(SH_ROR_CIRC) : 3'(SH_ROL_CIRC);
            dec_o.sel      = SEL_ACC;
            dec_o.is_mem   = 1'b0;
            dec_o.acc_form = 1'b1;
        end
    end
endmodule

// File: rtl/bitmanip_shifter.sv
module bitmanip_shifter
    import bitmanip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value_i,
    input  shop_e             op_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] swapped;

    genvar g;
    generate
        for (g = 0; g < HALF_W; g++) begin : g_swap
            assign swapped[g]          = value_i[g + HALF_W];
            assign swapped[g + HALF_W] = value_i[g];
        end
    endgenerate

    always_comb begin
        result_o = value_i;
        carry_o  = 1'b0;
        unique case (op_i)
            SH_ROL_CIRC: begin
                result_o = {value_i[DATA_W-2:0], value_i[DATA_W-1]};
                carry_o  = value_i[DATA_W-1];
            end
            SH_ROR_CIRC: begin
                result_o = {value_i[0], value_i[DATA_W-1:1]};
                carry_o  = value_i[0];
            end
            SH_ROL_CARRY: begin
                result_o = {value_i[DATA_W-2:0], carry_i};
                carry_o  = value_i[DATA_W-1];
            end
            SH_ROR_CARRY: begin
                result_o = {carry_i, value_i[DATA_W-1:1]};
                carry_o  = value_i[0];
            end
            SH_SHL: begin
                result_o = {value_i[DATA_W-2:0], 1'b0};
                carry_o  = value_i[DATA_W-1];
            end
            SH_SHR_ARITH: begin
                result_o = {value_i[DATA_W-1], value_i[DATA_W-1:1]};
                carry_o  = value_i[0];
            end
            SH_NIB_SWAP: begin
                result_o = swapped;
                carry_o  = 1'b0;
            end
            SH_SHR_LOGIC: begin
                result_o = {1'b0, value_i[DATA_W-1:1]};
                carry_o  = value_i[0];
            end
            default: begin
                result_o = value_i;
                carry_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bitmanip_bitops.sv
module bitmanip_bitops
    import bitmanip_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  grp_e              grp_i,
    output logic [DATA_W-1:0] result_o,
    output logic              tested_o
);
    logic [DATA_W-1:0] onehot;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_mask
            assign onehot[g] = (idx_i == IDX_W'(g));
        end
    endgenerate

    assign tested_o = |(value_i & onehot);

    always_comb begin
        unique case (grp_i)
            GRP_CLEAR: result_o = value_i & ~onehot;
            GRP_SET:   result_o = value_i | onehot;
            default:   result_o = value_i;
        endcase
    end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bitmanip_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REG_CYCLES = 2,
    parameter int MEM_EXTRA  = 2,
    parameter int ACC_CYCLES = 1,
    parameter int CYC_W      = $clog2(REG_CYCLES + MEM_EXTRA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              prefixed_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [3:0]        flags_i,
    output logic [2:0]        src_sel_o,
    output logic              src_is_mem_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_we_o,
    output logic [3:0]        flags_o,
    output logic [3:0]        flag_mask_o,
    output logic [CYC_W-1:0]  cycles_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CYC_W-1:0] CYC_REG = CYC_W'(REG_CYCLES);
    localparam logic [CYC_W-1:0] CYC_MEM = CYC_W'(REG_CYCLES + MEM_EXTRA);
    localparam logic [CYC_W-1:0] CYC_ACC = CYC_W'(ACC_CYCLES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              we;
        logic [3:0]        flags;
        logic [3:0]        mask;
        logic [CYC_W-1:0]  cycles;
    } state_t;

    dec_t              dec;
    logic [DATA_W-1:0] sh_result;
    logic              sh_carry;
    logic [DATA_W-1:0] bit_result;
    logic              bit_tested;
    state_t            st_d;
    state_t            st_q;

    bitmanip_decode u_decode (
        .prefixed_i (prefixed_i),
        .opcode_i   (opcode_i),
        .dec_o      (dec)
    );

    bitmanip_shifter #(.DATA_W(DATA_W)) u_shifter (
        .value_i  (operand_i),
        .op_i     (shop_e'(dec.idx)),
        .carry_i  (flags_i[FLG_C]),
        .result_o (sh_result),
        .carry_o  (sh_carry)
    );

    bitmanip_bitops #(.DATA_W(DATA_W)) u_bitops (
        .value_i  (operand_i),
        .idx_i    (dec.idx[IDX_W-1:0]),
        .grp_i    (dec.grp),
        .result_o (bit_result),
        .tested_o (bit_tested)
    );

    assign src_sel_o    = dec.sel;
    assign src_is_mem_o = dec.is_mem;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (start_i) begin
            st_d.valid  = 1'b1;
            st_d.flags  = flags_i;
            st_d.cycles = dec.acc_form ? CYC_ACC : (dec.is_mem ? CYC_MEM : CYC_REG);
            unique case (dec.grp)
                GRP_SHIFT: begin
                    st_d.result       = sh_result;
                    st_d.we           = 1'b1;
                    st_d.mask         = 4'b1111;
                    st_d.flags[FLG_Z] = dec.acc_form ? 1'b0 : (sh_result == '0);
                    st_d.flags[FLG_N] = 1'b0;
                    st_d.flags[FLG_H] = 1'b0;
                    st_d.flags[FLG_C] = sh_carry;
                end
                GRP_TEST: begin
                    st_d.result       = operand_i;
                    st_d.we           = 1'b0;
                    st_d.mask         = 4'b1110;
                    st_d.flags[FLG_Z] = ~bit_tested;
                    st_d.flags[FLG_N] = 1'b0;
                    st_d.flags[FLG_H] = 1'b1;
                end
                default: begin
                    st_d.result = bit_result;
                    st_d.we     = 1'b1;
                    st_d.mask   = 4'b0000;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o     = st_q.valid;
    assign result_o    = st_q.result;
    assign result_we_o = st_q.we;
    assign flags_o     = st_q.flags;
    assign flag_mask_o = st_q.mask;
    assign cycles_o    = st_q.cycles;

    p_test_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:6] == 2'b01)
        |=> (valid_o && !result_we_o && flag_mask_o == 4'b1110
             && flags_o[FLG_H] && !flags_o[FLG_N]));

    p_clear_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:6] == 2'b10)
        |=> (result_o[$past(opcode_i[5:3])] == 1'b0 && flag_mask_o == 4'b0000 && result_we_o));

    p_set_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:6] == 2'b11)
        |=> (result_o[$past(opcode_i[5:3])] == 1'b1 && flag_mask_o == 4'b0000 && result_we_o));

    p_circ_keeps_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:4] == 4'b0000)
        |=> ($countones(result_o) == $countones($past(operand_i))));

    p_swap_clears_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:3] == 5'b00110)
        |=> (!flags_o[FLG_C]));

    p_shift_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[7:6] == 2'b00)
        |=> (flags_o[FLG_Z] == (result_o == '0) && !flags_o[FLG_N] && !flags_o[FLG_H]
             && flag_mask_o == 4'b1111));

    p_mem_cost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prefixed_i && opcode_i[2:0] == SEL_MEM)
        |=> (cycles_o == CYC_MEM));

    p_acc_no_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !prefixed_i) |=> (flags_o[3:1] == 3'b000 && result_we_o));

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i) |=> (!valid_o));

endmodule

// File: tb/bitmanip_unit_bench.sv
module bitmanip_unit_bench;

    typedef struct packed {
        logic [7:0] result;
        logic       we;
        logic [3:0] flags;
        logic [3:0] mask;
        logic [2:0] cycles;
        logic [3:0] req;
        logic       shift_grp;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       prefixed_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] operand_i = 8'h00;
    logic [3:0] flags_i = 4'h0;
    logic [2:0] src_sel_o;
    logic       src_is_mem_o;
    logic       valid_o;
    logic [7:0] result_o;
    logic       result_we_o;
    logic [3:0] flags_o;
    logic [3:0] flag_mask_o;
    logic [2:0] cycles_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    bitmanip_unit u_bitmanip_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .prefixed_i   (prefixed_i),
        .opcode_i     (opcode_i),
        .operand_i    (operand_i),
        .flags_i      (flags_i),
        .src_sel_o    (src_sel_o),
        .src_is_mem_o (src_is_mem_o),
        .valid_o      (valid_o),
        .result_o     (result_o),
        .result_we_o  (result_we_o),
        .flags_o      (flags_o),
        .flag_mask_o  (flag_mask_o),
        .cycles_o     (cycles_o)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit pre, input logic [7:0] op,
                                   input logic [7:0] v, input logic [3:0] f);
        exp_t e;
        logic [7:0] r;
        logic       c;
        int         b;
        e.flags     = f;
        e.result    = v;
        e.we        = 1'b1;
        e.mask      = 4'b0000;
        e.shift_grp = 1'b0;
        if (!pre) begin
            if (op[3]) begin r = {v[0], v[7:1]}; c = v[0]; end
            else       begin r = {v[6:0], v[7]}; c = v[7]; end
            e.result = r;
            e.flags  = {3'b000, c};
            e.mask   = 4'b1111;
            e.cycles = 3'd1;
            e.req    = 4'd12;
            return e;
        end
        e.cycles = (op[2:0] == 3'd6) ? 3'd4 : 3'd2;
        b = int'(op[5:3]);
        case (op[7:6])
            2'b01: begin
                e.we    = 1'b0;
                e.mask  = 4'b1110;
                e.flags = {~v[b], 1'b0, 1'b1, f[0]};
                e.req   = 4'd3;
            end
            2'b10: begin
                r = v; r[b] = 1'b0; e.result = r; e.req = 4'd4;
            end
            2'b11: begin
                r = v; r[b] = 1'b1; e.result = r; e.req = 4'd5;
            end
            default: begin
                case (op[5:3])
                    3'd0: begin r = {v[6:0], v[7]}; c = v[7]; e.req = 4'd6; end
                    3'd1: begin r = {v[0], v[7:1]}; c = v[0]; e.req = 4'd6; end
                    3'd2: begin r = {v[6:0], f[0]}; c = v[7]; e.req = 4'd7; end
                    3'd3: begin r = {f[0], v[7:1]}; c = v[0]; e.req = 4'd7; end
                    3'd4: begin r = {v[6:0], 1'b0}; c = v[7]; e.req = 4'd8; end
                    3'd5: begin r = {v[7], v[7:1]}; c = v[0]; e.req = 4'd8; end
                    3'd6: begin r = {v[3:0], v[7:4]}; c = 1'b0; e.req = 4'd9; end
                    default: begin r = {1'b0, v[7:1]}; c = v[0]; e.req = 4'd8; end
                endcase
                e.result    = r;
                e.flags     = {(r == 8'h00), 1'b0, 1'b0, c};
                e.mask      = 4'b1111;
                e.shift_grp = 1'b1;
            end
        endcase
        return e;
    endfunction

    task automatic issue(input bit pre, input logic [7:0] op,
                         input logic [7:0] v, input logic [3:0] f);
        @(negedge clk);
        prefixed_i = pre;
        opcode_i   = op;
        operand_i  = v;
        flags_i    = f;
        #1;
        // R1: operand select is combinational from the opcode
        check(src_sel_o == (pre ? op[2:0] : 3'd7), "R1", "src_sel",
              32'(src_sel_o), 32'(pre ? op[2:0] : 3'd7));
        check(src_is_mem_o == (pre && op[2:0] == 3'd6), "R1", "src_is_mem",
              32'(src_is_mem_o), 32'(pre && op[2:0] == 3'd6));
        sb.push_back(model(pre, op, v, f));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected valid", 32'(valid_o), 32'd0);
            end else begin
                exp_t e;
                string rq;
                string fr;
                e  = sb.pop_front();
                rq = req_name(e.req);
                fr = e.shift_grp ? "R10" : rq;
                check(result_o == e.result, rq, "result", 32'(result_o), 32'(e.result));
                check(result_we_o == e.we, fr, "result_we", 32'(result_we_o), 32'(e.we));
                check(flags_o == e.flags, fr, "flags", 32'(flags_o), 32'(e.flags));
                check(flag_mask_o == e.mask, fr, "flag_mask", 32'(flag_mask_o), 32'(e.mask));
                check(cycles_o == e.cycles, "R11", "cycles", 32'(cycles_o), 32'(e.cycles));
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
    end

    initial begin
        logic [7:0] opnds [6];
        opnds = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'hFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state of every registered output
        check(valid_o == 1'b0, "R2", "valid after reset", 32'(valid_o), 32'd0);
        check(result_o == 8'h00 && result_we_o == 1'b0, "R2", "result after reset",
              32'({result_o, result_we_o}), 32'd0);
        check(flags_o == 4'h0 && flag_mask_o == 4'h0 && cycles_o == 3'd0, "R2",
              "flags/mask/cycles after reset", 32'({flags_o, flag_mask_o, cycles_o}), 32'd0);

        // Sweep all prefixed opcodes over boundary operands and both carry states
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 6; k++) begin
                issue(1'b1, 8'(op), opnds[k], (k % 2 == 0) ? 4'b0001 : 4'b1110);
            end
        end

        // R12: accumulator rotates, including a zero result that keeps Z clear
        for (int k = 0; k < 6; k++) begin
            issue(1'b0, 8'h07, opnds[k], 4'b1111);
            issue(1'b0, 8'h0F, opnds[k], 4'b0000);
        end

        // R7: carry-in sensitivity on a fixed operand
        issue(1'b1, 8'h10, 8'h00, 4'b0001);
        issue(1'b1, 8'h18, 8'h00, 4'b0001);

        // R2: valid must drop on an idle cycle
        @(negedge clk);
        check(valid_o == 1'b0, "R2", "valid on idle", 32'(valid_o), 32'd0);
        check(sb.size() == 0, "R2", "missing results", 32'(sb.size()), 32'd0);
        summary();
    end

endmodule